// File: doc/BRIEF.md
# Paged Pixel Input Lookup Table

This block maps each 12-bit converter sample onto a 16-bit output word through a host-loaded table. The table is split into pages of 4096 entries. A static page-select input picks which page is used, so several transforms can stay loaded at once. Switching between them only means changing the page select; no entry has to be rewritten. Before the sample indexes the page, its bits are reversed: the sample's most significant bit becomes the least significant address bit.

The host fills the table through a write port that covers a 19-bit byte-offset space. Only offsets 0x40000 through 0x7FFFF reach the table. Each 32-bit-aligned word there is one entry, and only the low half of the write data is kept. A pixel lookup is a registered read. Its result and a valid flag appear one clock after the input strobe.

The number of pages actually built is the parameter `LUT_PAGES`. It must be a power of two from 2 to 16. The bench uses 4.

Top module: `pixel_lut`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `out_data` are 0 after that edge.
- R2: `out_valid` is high in exactly those cycles that follow a clock edge at which `pix_valid` was high.
- R3: The read address takes sample bit k onto position 11−k (k = 0..11), so sample bit 11 lands on address bit 0.
- R4: The read index is page × 4096 + reversed sample, where page is `page_sel` modulo `LUT_PAGES`. Changing `page_sel` selects another loaded page, and no table write is needed.
- R5: A write with `host_addr[18]`=1 stores `host_wdata[15:0]` at entry `host_addr[17:2]`. Entry bits 15:12 give the page and bits 11:0 give the position. `host_wdata[31:16]` is discarded.
- R6: A write with `host_addr[18]`=0 lies outside the window and changes no entry.
- R7: A windowed write whose page field `host_addr[17:14]` is `LUT_PAGES` or more changes no entry.
- R8: `host_addr[1:0]` has no effect on which entry a write hits.
- R9: When a write and a lookup hit the same entry at the same edge, the lookup returns the value from before the write. The next lookup returns the new value.
- R10: `out_data` holds its value in cycles that follow an edge without `pix_valid`.
- R11: All 16 stored bits, including tag bits 15:12, reach `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 19 | Host byte offset |
| host_wdata | input | 32 | Host write data; low 16 bits are stored |
| page_sel | input | 4 | Static page select |
| pix_valid | input | 1 | Sample strobe |
| pix_adc | input | 12 | Converter sample |
| out_valid | output | 1 | Lookup result valid |
| out_data | output | 16 | Looked-up word |

## Verification
Each page is loaded with its own entry function, and the tag bits differ from page to page. A wrong page or a lost tag bit therefore shows up as a different word. Walking single-bit samples tell a correct reversal apart from a straight or shifted address, because each bit reaches exactly one entry. Pseudo-random samples and page-select values with the upper bits set cover the rest of the address space and check the page wrap. The bench also directs writes that must be ignored (outside the window, to a page that is not built, with junk in the upper data half, with unaligned low offset bits). It makes same-entry write/lookup collisions and idle gaps. The behavioural model is compared on every clock, so it can tell an ignored write from a stored one and old data from new.

// File: rtl/pixel_lut_pkg.sv
package pixel_lut_pkg;

    localparam int ADC_W  = 12;
    localparam int PAGE_W = 4;
    localparam int WORD_W = 16;
    localparam int BUS_W  = 32;
    localparam int OFFS_W = 19;
    localparam int IDX_W  = PAGE_W + ADC_W;

    typedef logic [ADC_W-1:0]  sample_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        page_t   page;
        sample_t pos;
    } entry_idx_t;

    typedef struct packed {
        logic       en;
        entry_idx_t idx;
        word_t      data;
    } wr_req_t;

    typedef struct packed {
        logic       en;
        entry_idx_t idx;
    } rd_req_t;

    function automatic sample_t mirror_sample(input sample_t s);
        sample_t r;
        for (int k = 0; k < ADC_W; k++) begin
            r[ADC_W-1-k] = s[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/pixel_lut_host_dec.sv
module pixel_lut_host_dec
    import pixel_lut_pkg::*;
#(
    parameter int LUT_PAGES = 2
) (
    input  logic              host_we,
    input  logic [OFFS_W-1:0] host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    output wr_req_t           wr_req
);
    localparam logic [PAGE_W:0] PAGES_L = LUT_PAGES[PAGE_W:0];

    entry_idx_t idx;
    logic       in_window;
    logic       page_ok;
    logic       unused_dec;

    assign idx        = entry_idx_t'(host_addr[OFFS_W-2:2]);
    assign in_window  = host_addr[OFFS_W-1];
    assign page_ok    = {1'b0, idx.page} < PAGES_L;
    assign unused_dec = ^{host_addr[1:0], host_wdata[BUS_W-1:WORD_W]};

    always_comb begin
        wr_req.en   = host_we && in_window && page_ok;
        wr_req.idx  = idx;
        wr_req.data = host_wdata[WORD_W-1:0];
    end

endmodule

// File: rtl/pixel_lut_addr_form.sv
module pixel_lut_addr_form
    import pixel_lut_pkg::*;
(
    input  logic    pix_valid,
    input  sample_t pix_adc,
    input  page_t   page_sel,
    output rd_req_t rd_req
);
    always_comb begin
        rd_req.en       = pix_valid;
        rd_req.idx.page = page_sel;
        rd_req.idx.pos  = mirror_sample(pix_adc);
    end

endmodule

// File: rtl/pixel_lut_store.sv
module pixel_lut_store
    import pixel_lut_pkg::*;
#(
    parameter int LUT_PAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr_req,
    input  rd_req_t rd_req,
    output word_t   rd_data
);
    localparam int PG_IW = $clog2(LUT_PAGES);
    localparam int LIDX_W = PG_IW + ADC_W;
    localparam int DEPTH = LUT_PAGES << ADC_W;

    word_t mem [DEPTH];
    logic [LIDX_W-1:0] wr_loc;
    logic [LIDX_W-1:0] rd_loc;
    word_t rd_q;

    assign wr_loc = {wr_req.idx.page[PG_IW-1:0], wr_req.idx.pos};
    assign rd_loc = {rd_req.idx.page[PG_IW-1:0], rd_req.idx.pos};

    generate
        if (PG_IW < PAGE_W) begin : g_trunc
            logic unused_pg;
            assign unused_pg = ^{wr_req.idx.page[PAGE_W-1:PG_IW],
                                 rd_req.idx.page[PAGE_W-1:PG_IW]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_req.en) begin
            mem[wr_loc] <= wr_req.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_req.en) begin
            rd_q <= mem[rd_loc];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/pixel_lut.sv
module pixel_lut
    import pixel_lut_pkg::*;
#(
    parameter int LUT_PAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [OFFS_W-1:0] host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              pix_valid,
    input  logic [ADC_W-1:0]  pix_adc,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    wr_req_t wr_req;
    rd_req_t rd_req;
    word_t   rd_data;
    logic    valid_q;

    pixel_lut_host_dec #(.LUT_PAGES(LUT_PAGES)) u_dec (
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .wr_req     (wr_req)
    );

    pixel_lut_addr_form u_form (
        .pix_valid (pix_valid),
        .pix_adc   (pix_adc),
        .page_sel  (page_sel),
        .rd_req    (rd_req)
    );

    pixel_lut_store #(.LUT_PAGES(LUT_PAGES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_req.en;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = rd_data;

endmodule

// File: rtl/pixel_lut_chk.sv
module pixel_lut_chk
    import pixel_lut_pkg::*;
#(
    parameter int LUT_PAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [OFFS_W-1:0] host_addr,
    input logic              pix_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              store_we
);
    localparam logic [PAGE_W:0] PAGES_L = LUT_PAGES[PAGE_W:0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> $stable(out_data));

    // R6
    window_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && !host_addr[OFFS_W-1]) |-> !store_we);

    // R7
    page_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && ({1'b0, host_addr[OFFS_W-2:OFFS_W-1-PAGE_W]} >= PAGES_L)) |-> !store_we);

endmodule

bind pixel_lut pixel_lut_chk #(.LUT_PAGES(LUT_PAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_addr (host_addr),
    .pix_valid (pix_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .store_we  (wr_req.en)
);

// File: tb/pixel_lut_bench.sv
module pixel_lut_bench;

    localparam int PAGES = 4;
    localparam int ENT   = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  page_sel = '0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_adc = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    int model [PAGES*ENT];
    int exp_valid = 0;
    int exp_data = 0;

    pixel_lut #(.LUT_PAGES(PAGES)) u_pixel_lut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .page_sel(page_sel), .pix_valid(pix_valid),
        .pix_adc(pix_adc), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    function automatic int mirror12(input int a);
        int r = 0;
        int v = a;
        for (int i = 0; i < 12; i++) begin
            r = r * 2 + (v % 2);
            v = v / 2;
        end
        return r;
    endfunction

    function automatic int fill_val(input int pg, input int pos);
        return ((pg * 4 + 3) * 4096 + ((pos * 37 + pg * 911) % 4096)) % 65536;
    endfunction

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            exp_valid = 0;
            exp_data  = 0;
        end else begin
            if (pix_valid) begin
                exp_data = model[(int'(page_sel) % PAGES) * ENT + mirror12(int'(pix_adc))];
            end
            exp_valid = int'(pix_valid);
            if (host_we && host_addr[18] && (int'(host_addr[17:14]) < PAGES)) begin
                model[int'(host_addr[17:2])] = int'(host_wdata) & 32'hFFFF;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            tests++;
            if (int'(out_valid) != exp_valid || int'(out_data) != exp_data) begin
                fails++;
                $display("FAIL %s cycle %0d: valid=%0d data=%h expected valid=%0d data=%h",
                         cur_req, cycles, out_valid, out_data, exp_valid, exp_data[15:0]);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_we = 1'b0;
            pix_valid = 1'b0;
        end
    endtask

    task automatic hwrite(input logic [18:0] a, input logic [31:0] d);
        @(negedge clk);
        pix_valid = 1'b0;
        host_we = 1'b1;
        host_addr = a;
        host_wdata = d;
    endtask

    task automatic look(input int pg, input int adc);
        @(negedge clk);
        host_we = 1'b0;
        page_sel = pg[3:0];
        pix_valid = 1'b1;
        pix_adc = adc[11:0];
    endtask

    function automatic logic [18:0] waddr(input int pg, input int pos, input int low);
        return 19'(32'h40000 + (pg * ENT + pos) * 4 + low);
    endfunction

    initial begin
        int seed;
        seed = 7;
        for (int i = 0; i < PAGES*ENT; i++) model[i] = 0;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R5 / R11: load every page, junk in upper data half
        cur_req = "R5";
        for (int p = 0; p < PAGES; p++)
            for (int q = 0; q < ENT; q++)
                hwrite(waddr(p, q, 0), {16'hA5C3 ^ 16'(q), 16'(fill_val(p, q))});
        idle(2);

        // R3: walking single-bit samples on each page
        cur_req = "R3";
        for (int p = 0; p < PAGES; p++)
            for (int b = 0; b < 12; b++) look(p, 1 << b);
        look(0, 0);
        look(1, 12'hFFF);
        idle(2);

        // R4: switch pages on the same sample without reloading
        cur_req = "R4";
        for (int p = 0; p < PAGES; p++) begin
            look(p, 12'h123);
            look(p, 12'hABC);
        end
        // R11: pseudo-random samples, tag bits differ by page
        cur_req = "R11";
        for (int i = 0; i < 400; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            look(seed % PAGES, (seed / 16) % 4096);
        end
        // R4: page_sel upper bits wrap modulo page count
        cur_req = "R4";
        look(6, 12'h0F1);
        look(15, 12'h801);
        look(9, 12'h7E0);

        // R10: output holds through idle gaps
        cur_req = "R10";
        idle(5);
        look(2, 12'h555);
        idle(4);

        // R6: write outside window ignored, then read the aliased entry
        cur_req = "R6";
        hwrite(19'((1 * ENT + 12'h30C) * 4), 32'h0000BEEF);
        look(1, mirror12(12'h30C));
        idle(2);

        // R7: write to page beyond those built is ignored
        cur_req = "R7";
        hwrite(waddr(5, 12'h044, 0), 32'h00001234);
        look(1, mirror12(12'h044));
        look(5, mirror12(12'h044));
        idle(2);

        // R8: low offset bits do not move the target entry
        cur_req = "R8";
        hwrite(waddr(2, 12'h100, 3), 32'h0000C0DE);
        hwrite(waddr(2, 12'h101, 1), 32'h00007ACE);
        look(2, mirror12(12'h100));
        look(2, mirror12(12'h101));
        look(2, mirror12(12'h0FF));
        idle(2);

        // R9: same-entry write and lookup in one cycle, then re-read
        cur_req = "R9";
        @(negedge clk);
        host_we = 1'b1;
        host_addr = waddr(3, 12'h2A7, 0);
        host_wdata = 32'h0000F00D;
        page_sel = 4'd3;
        pix_valid = 1'b1;
        pix_adc = 12'(mirror12(12'h2A7));
        look(3, mirror12(12'h2A7));
        idle(2);

        // R2: strobe patterns, back-to-back and sparse
        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin
            look(i % PAGES, i * 300);
            if (i % 3 == 0) idle(1);
        end
        idle(2);

        // R1: reset in mid-stream clears outputs
        cur_req = "R1";
        look(0, 12'h3FF);
        @(negedge clk);
        rst = 1'b1;
        pix_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule